// File: doc/BRIEF.md
# Dual-Port RAM with Mailbox Interrupts

A synchronous two-port memory in which each side, called A and B, has its own select, write enable, output enable, address and data lines. Either side can read or write any word on its own, in the same cycle as the other side. The two highest addresses also act as mailboxes between the sides:

- A write by B to the second-highest address flags an interrupt toward A.
- A write by A to the highest address flags an interrupt toward B.
- Each side clears its own flag by accessing its mailbox.

The mailbox words remain ordinary storage, so the message they carry is entirely up to software. A static enable input turns the mailbox feature off. The two top words are then plain memory and neither flag moves.

The depth is set by `ADDR_W`. With the default of 10, the mailbox addresses are 0x3FE (toward A) and 0x3FF (toward B). Setting `ADDR_W` to 16 gives a 64K-word array with mailboxes at 0xFFFE and 0xFFFF.

Top module: `dpram_mailbox`

## Requirements
- R1: After reset, `a_irq_n` and `b_irq_n` are both 1 (inactive) and `a_rdata` and `b_rdata` are both 0.
- R2: A side reads when its select is 1, its output enable is 1 and its write enable is 0. The word at its address appears on its read data on the cycle after the read. A side writes when its select and write enable are both 1. Either side can reach any address.
- R3: A side whose select is 0 does nothing: it stores no data, its read data holds, and it neither sets nor clears a flag.
- R4: With `mbox_on` = 1, a write by side B to address 2^ADDR_W-2 drives `a_irq_n` to 0 on the following cycle.
- R5: With `mbox_on` = 1, an access by side A to address 2^ADDR_W-2 with select and output enable both 1 drives `a_irq_n` back to 1 on the following cycle, whatever the value of A's write enable. If A's output enable is 0, the flag is not cleared.
- R6: With `mbox_on` = 1, a write by side A to address 2^ADDR_W-1 drives `b_irq_n` to 0 on the following cycle.
- R7: With `mbox_on` = 1, an access by side B to address 2^ADDR_W-1 with select and output enable both 1 drives `b_irq_n` back to 1 on the following cycle.
- R8: The mailbox words are normal storage. A message written by one side is read back unchanged by the other side.
- R9: With `mbox_on` = 0, neither flag changes, and both top addresses behave as ordinary memory.
- R10: If a set and a clear of the same flag fall in the same cycle, the set wins and the flag ends up active.
- R11: When one side reads a word in the same cycle that the other side writes it, the read returns the old content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mbox_on | input | 1 | Static enable for the mailbox interrupts |
| a_sel | input | 1 | Side A select |
| a_we | input | 1 | Side A write enable |
| a_oe | input | 1 | Side A output enable |
| a_addr | input | ADDR_W | Side A address |
| a_wdata | input | DATA_W | Side A write data |
| a_rdata | output | DATA_W | Side A registered read data |
| a_irq_n | output | 1 | Interrupt toward side A, active low |
| b_sel | input | 1 | Side B select |
| b_we | input | 1 | Side B write enable |
| b_oe | input | 1 | Side B output enable |
| b_addr | input | ADDR_W | Side B address |
| b_wdata | input | DATA_W | Side B write data |
| b_rdata | output | DATA_W | Side B registered read data |
| b_irq_n | output | 1 | Interrupt toward side B, active low |

## Verification
The assertions assume that `mbox_on` changes only between operations. They also assume that the two sides never write the same address in the same cycle, because the outcome of such a collision is left undefined.

The directed tests respect both assumptions:
- They change `mbox_on` only while both sides are deselected.
- They pair a write on one side only with a read, or with an access to a different address, on the other side.

Within those limits, the tests cover:
- set-over-clear races on one flag;
- clears with write enable both high and low;
- accesses with output enable low;
- reads and writes of the mailboxes while the feature is off.

// File: rtl/dpram_mailbox.sv
module dpram_mailbox #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mbox_on,
  input  logic              a_sel,
  input  logic              a_we,
  input  logic              a_oe,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_irq_n,
  input  logic              b_sel,
  input  logic              b_we,
  input  logic              b_oe,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_irq_n
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] BOX_A = {{(ADDR_W-1){1'b1}}, 1'b0};
  localparam logic [ADDR_W-1:0] BOX_B = {ADDR_W{1'b1}};

  logic [DATA_W-1:0] mem [DEPTH];
  logic flag_a, flag_b;

  wire a_wr = a_sel & a_we;
  wire b_wr = b_sel & b_we;
  wire a_rd = a_sel & a_oe & ~a_we;
  wire b_rd = b_sel & b_oe & ~b_we;

  wire set_a = mbox_on & b_wr & (b_addr == BOX_A);
  wire clr_a = mbox_on & a_sel & a_oe & (a_addr == BOX_A);
  wire set_b = mbox_on & a_wr & (a_addr == BOX_B);
  wire clr_b = mbox_on & b_sel & b_oe & (b_addr == BOX_B);

  always_ff @(posedge clk) begin
    if (a_wr) mem[a_addr] <= a_wdata;
    if (b_wr) mem[b_addr] <= b_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rdata <= '0;
      b_rdata <= '0;
    end else begin
      if (a_rd) a_rdata <= mem[a_addr];
      if (b_rd) b_rdata <= mem[b_addr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_a <= 1'b0;
      flag_b <= 1'b0;
    end else begin
      if (set_a)      flag_a <= 1'b1;
      else if (clr_a) flag_a <= 1'b0;
      if (set_b)      flag_b <= 1'b1;
      else if (clr_b) flag_b <= 1'b0;
    end
  end

  assign a_irq_n = ~flag_a;
  assign b_irq_n = ~flag_b;
endmodule

// File: rtl/dpram_mailbox_checks.sv
module dpram_mailbox_checks #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mbox_on,
  input logic              a_sel,
  input logic              a_we,
  input logic              a_oe,
  input logic [ADDR_W-1:0] a_addr,
  input logic [DATA_W-1:0] a_rdata,
  input logic              a_irq_n,
  input logic              b_sel,
  input logic              b_we,
  input logic              b_oe,
  input logic [ADDR_W-1:0] b_addr,
  input logic [DATA_W-1:0] b_rdata,
  input logic              b_irq_n
);
  localparam logic [ADDR_W-1:0] TOP1 = {{(ADDR_W-1){1'b1}}, 1'b0};
  localparam logic [ADDR_W-1:0] TOP0 = {ADDR_W{1'b1}};

  assert_rdata_a_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_sel && a_oe && !a_we) |=> $stable(a_rdata));
  assert_rdata_b_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(b_sel && b_oe && !b_we) |=> $stable(b_rdata));
  assert_set_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mbox_on && b_sel && b_we && b_addr == TOP1) |=> !a_irq_n);
  assert_clr_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mbox_on && a_sel && a_oe && a_addr == TOP1 && !(b_sel && b_we && b_addr == TOP1)) |=> a_irq_n);
  assert_set_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mbox_on && a_sel && a_we && a_addr == TOP0) |=> !b_irq_n);
  assert_clr_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mbox_on && b_sel && b_oe && b_addr == TOP0 && !(a_sel && a_we && a_addr == TOP0)) |=> b_irq_n);
  assert_off_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mbox_on |=> ($stable(a_irq_n) && $stable(b_irq_n)));
endmodule

bind dpram_mailbox dpram_mailbox_checks #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk (
  .clk(clk), .rst_n(rst_n), .mbox_on(mbox_on),
  .a_sel(a_sel), .a_we(a_we), .a_oe(a_oe), .a_addr(a_addr), .a_rdata(a_rdata), .a_irq_n(a_irq_n),
  .b_sel(b_sel), .b_we(b_we), .b_oe(b_oe), .b_addr(b_addr), .b_rdata(b_rdata), .b_irq_n(b_irq_n)
);

// File: tb/dpram_mailbox_test.sv
`timescale 1ns/1ps
module dpram_mailbox_test;
  localparam int AW = 10;
  localparam int DW = 16;
  localparam logic [AW-1:0] BOX_A = 10'h3FE;
  localparam logic [AW-1:0] BOX_B = 10'h3FF;

  logic clk = 1'b0, rst_n = 1'b0, mbox_on = 1'b1;
  logic a_sel = 0, a_we = 0, a_oe = 0, b_sel = 0, b_we = 0, b_oe = 0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0;
  logic [DW-1:0] a_rdata, b_rdata;
  logic a_irq_n, b_irq_n;
  int runs = 0, fails = 0;

  always #2.5 clk = ~clk;

  dpram_mailbox #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .mbox_on(mbox_on),
    .a_sel(a_sel), .a_we(a_we), .a_oe(a_oe), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_irq_n(a_irq_n),
    .b_sel(b_sel), .b_we(b_we), .b_oe(b_oe), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_irq_n(b_irq_n));

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive_a(logic s, logic w, logic o, logic [AW-1:0] ad, logic [DW-1:0] d);
    a_sel = s; a_we = w; a_oe = o; a_addr = ad; a_wdata = d;
  endtask
  task automatic drive_b(logic s, logic w, logic o, logic [AW-1:0] ad, logic [DW-1:0] d);
    b_sel = s; b_we = w; b_oe = o; b_addr = ad; b_wdata = d;
  endtask
  task automatic step();
    @(negedge clk);
    drive_a(0, 0, 0, '0, '0);
    drive_b(0, 0, 0, '0, '0);
  endtask

  task automatic t_reset();
    check("R1 a_irq_n", a_irq_n, 1);
    check("R1 b_irq_n", b_irq_n, 1);
    check("R1 a_rdata", a_rdata, 0);
    check("R1 b_rdata", b_rdata, 0);
  endtask

  task automatic t_basic();
    drive_a(1, 1, 0, 10'h005, 16'h1234); drive_b(1, 1, 0, 10'h007, 16'hABCD); step();
    drive_a(1, 0, 1, 10'h007, '0); drive_b(1, 0, 1, 10'h005, '0); step();
    check("R2 a reads b's word", a_rdata, 16'hABCD);
    check("R2 b reads a's word", b_rdata, 16'h1234);
  endtask

  task automatic t_deselect();
    drive_a(0, 1, 1, 10'h005, 16'hFFFF); drive_b(0, 1, 0, BOX_A, 16'h9999); step();
    check("R3 rdata holds when deselected", a_rdata, 16'hABCD);
    check("R3 no flag from deselected write", a_irq_n, 1);
    drive_a(1, 0, 1, 10'h005, '0); step();
    check("R3 deselected write stored nothing", a_rdata, 16'h1234);
  endtask

  task automatic t_box_a();
    drive_b(1, 1, 0, BOX_A, 16'h55AA); step();
    check("R4 a_irq_n set", a_irq_n, 0);
    check("R4 b_irq_n untouched", b_irq_n, 1);
    drive_a(1, 0, 0, BOX_A, '0); step();
    check("R5 no clear without output enable", a_irq_n, 0);
    drive_a(1, 0, 1, BOX_A, '0); step();
    check("R5 clear by read", a_irq_n, 1);
    check("R8 message seen by A", a_rdata, 16'h55AA);
    drive_b(1, 1, 0, BOX_A, 16'h66BB); step();
    check("R4 set again", a_irq_n, 0);
    drive_a(1, 1, 1, BOX_A, 16'h77CC); step();
    check("R5 clear with write enable high", a_irq_n, 1);
  endtask

  task automatic t_box_b();
    drive_a(1, 1, 0, BOX_B, 16'h1357); step();
    check("R6 b_irq_n set", b_irq_n, 0);
    check("R6 a_irq_n untouched", a_irq_n, 1);
    drive_b(1, 0, 1, BOX_B, '0); step();
    check("R7 clear by read", b_irq_n, 1);
    check("R8 message seen by B", b_rdata, 16'h1357);
  endtask

  task automatic t_set_wins();
    drive_b(1, 1, 0, BOX_A, 16'h2468); drive_a(1, 0, 1, BOX_A, '0); step();
    check("R10 set beats clear on a", a_irq_n, 0);
    check("R11 old data on a", a_rdata, 16'h77CC);
    drive_a(1, 0, 1, BOX_A, '0); step();
    check("R5 clear after race", a_irq_n, 1);
    drive_a(1, 1, 0, BOX_B, 16'h0001); drive_b(1, 0, 1, BOX_B, '0); step();
    check("R10 set beats clear on b", b_irq_n, 0);
    drive_b(1, 0, 1, BOX_B, '0); step();
    check("R7 clear after race", b_irq_n, 1);
  endtask

  task automatic t_disabled();
    mbox_on = 0;
    drive_b(1, 1, 0, BOX_A, 16'h0F0F); drive_a(1, 1, 0, BOX_B, 16'hF0F0); step();
    check("R9 no set on a when off", a_irq_n, 1);
    check("R9 no set on b when off", b_irq_n, 1);
    drive_a(1, 0, 1, BOX_A, '0); drive_b(1, 0, 1, BOX_B, '0); step();
    check("R9 box A plain memory", a_rdata, 16'h0F0F);
    check("R9 box B plain memory", b_rdata, 16'hF0F0);
    mbox_on = 1;
    drive_b(1, 1, 0, BOX_A, 16'h0A0A); step();
    mbox_on = 0;
    drive_a(1, 0, 1, BOX_A, '0); step();
    check("R9 flag held when off", a_irq_n, 0);
    mbox_on = 1;
    drive_a(1, 0, 1, BOX_A, '0); step();
    check("R5 clear after re-enable", a_irq_n, 1);
  endtask

  task automatic t_collide();
    drive_a(1, 1, 0, 10'h009, 16'h1111); step();
    drive_a(1, 1, 0, 10'h009, 16'h2222); drive_b(1, 0, 1, 10'h009, '0); step();
    check("R11 read sees old word", b_rdata, 16'h1111);
    drive_b(1, 0, 1, 10'h009, '0); step();
    check("R11 new word afterwards", b_rdata, 16'h2222);
  endtask

  initial begin
    #20000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_basic();
    t_deselect();
    t_box_a();
    t_box_b();
    t_set_wins();
    t_disabled();
    t_collide();
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule